// File: doc/BRIEF.md
# Serial Controller Interrupt Priority Encoder

This block merges the interrupt sources of a 16550-style serial controller into one identification byte and one level interrupt line. It holds the interrupt enable register and the transmit-empty pending flag. All other source flags come in as levels from the receiver, the transmitter, the FIFO control and the modem-status logic. Those blocks sit outside this one.

A bus decoder drives the strobes. It pulses `ier_wr_i` when software writes the enable register, `thr_wr_i` when software writes a transmit byte and `iir_rd_i` when software reads the identification register. The transmitter pulses `xmit_done_i` once the holding register has been moved out and is empty. At each moment exactly one source is reported: the enabled and active source with the highest fixed priority. The received-data source is qualified by the receive FIFO fill level whenever the FIFOs are on.

Top module: `serial_irq_arbiter`

## Requirements
- R1: When several enabled sources are active, the reported one is chosen by a fixed ranking. Line status is highest, then character timeout, then received data, then transmit empty, and modem status is lowest.
- R2: Bits 3:0 of `iir_o` hold the identification code: 0x6 line status, 0xC character timeout, 0x4 received data, 0x2 transmit empty, 0x0 modem status, and 0x1 when nothing is pending.
- R3: The enable register stores only bits 3:0 of a write, and `ier_o[7:4]` reads 0. The enable bits are: bit 0 received data and character timeout, bit 1 transmit empty, bit 2 line status, bit 3 modem status.
- R4: The line-status source is active when any bit of `line_err_i` is set. The bit mapping is [0] overrun, [1] parity, [2] framing, [3] break.
- R5: The character-timeout source is reported only when enable bit 0 is set.
- R6: With `fifo_en_i` high, received data is reported only when `data_ready_i` is high and `rx_count_i >= rx_level_i`. With `fifo_en_i` low, `data_ready_i` alone is enough.
- R7: The transmit-empty pending flag is cleared in two cases: by an `iir_rd_i` strobe in a cycle where `iir_o[3:0]` is 0x2, and by a `thr_wr_i` strobe. An `iir_rd_i` strobe while another code is shown leaves the flag set.
- R8: The pending flag is set in two cases: by `xmit_done_i`, and by `ier_wr_i` while `thr_empty_i` is high. If a set and a clear arrive in the same cycle, the set wins.
- R9: `iir_o[7:6]` reads 11 when `fifo_en_i` is high and 00 otherwise. `iir_o[5:4]` is always 0.
- R10: `irq_o` is high exactly when `iir_o[3:0]` is not 0x1.
- R11: After reset the enable register and the pending flag are 0, so `iir_o[3:0]` is 0x1 and `irq_o` is low.
- R12: A strobe takes effect on the outputs right after the clock edge that samples it. A change on a source input shows on `iir_o` and `irq_o` in the same cycle, with no register on the way.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| ier_wr_i | input | 1 | Enable register write strobe |
| ier_wdata_i | input | 8 | Enable register write data |
| ier_o | output | 8 | Enable register read value |
| iir_rd_i | input | 1 | Identification register read strobe |
| iir_o | output | 8 | Identification register value |
| thr_wr_i | input | 1 | Transmit byte write strobe |
| thr_empty_i | input | 1 | Transmit holding register is empty |
| xmit_done_i | input | 1 | Transmitter emptied the holding register |
| fifo_en_i | input | 1 | FIFOs enabled |
| line_err_i | input | 4 | Overrun, parity, framing, break flags |
| char_tmo_i | input | 1 | Character timeout pending |
| data_ready_i | input | 1 | Receive data ready |
| rx_count_i | input | CNT_W | Receive FIFO fill count |
| rx_level_i | input | CNT_W | Receive FIFO trigger level |
| modem_delta_i | input | 4 | Modem status change flags |
| irq_o | output | 1 | Level interrupt |

## Verification
Source inputs reach `iir_o` and `irq_o` through logic alone. The bench therefore drives them on the falling edge and checks a nanosecond later, within the same cycle. Strobes are sampled by the next rising edge, and their effect is due in the cycle that follows. The bench holds each strobe for one full cycle, drops it on the next falling edge and only then checks. A check taken one edge early would see the old state and fail.

// File: rtl/serial_irq_pkg.sv
package serial_irq_pkg;
  localparam int REG_W   = 8;
  localparam int EN_W    = 4;
  localparam int NUM_SRC = 5;

  localparam int EN_RX    = 0;
  localparam int EN_TXE   = 1;
  localparam int EN_LINE  = 2;
  localparam int EN_MODEM = 3;

  typedef enum logic [3:0] {
    ID_MODEM = 4'h0,
    ID_NONE  = 4'h1,
    ID_TXE   = 4'h2,
    ID_RXD   = 4'h4,
    ID_LINE  = 4'h6,
    ID_TMO   = 4'hC
  } irq_id_e;

  // rank 0 is highest
  function automatic irq_id_e rank_id(input int rank);
    case (rank)
      0:       return ID_LINE;
      1:       return ID_TMO;
      2:       return ID_RXD;
      3:       return ID_TXE;
      default: return ID_MODEM;
    endcase
  endfunction
endpackage

// File: rtl/irq_enable_reg.sv
module irq_enable_reg
  import serial_irq_pkg::*;
(
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             wr_i,
  input  logic [REG_W-1:0] wdata_i,
  output logic [EN_W-1:0]  en_o
);
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)   en_o <= '0;
    else if (wr_i) en_o <= wdata_i[EN_W-1:0];
  end

  AST_IER_LOW_BITS: assert property (@(posedge clk_i) disable iff (!rst_ni)
    wr_i |=> en_o == $past(wdata_i[EN_W-1:0])); // R3
endmodule

// File: rtl/txe_pending.sv
module txe_pending
  import serial_irq_pkg::*;
(
  input  logic    clk_i,
  input  logic    rst_ni,
  input  logic    xmit_done_i,
  input  logic    ier_wr_i,
  input  logic    thr_empty_i,
  input  logic    thr_wr_i,
  input  logic    id_rd_i,
  input  irq_id_e cur_id_i,
  output logic    pend_o
);
  logic set_ev, clr_ev;

  assign set_ev = xmit_done_i | (ier_wr_i & thr_empty_i);
  assign clr_ev = thr_wr_i | (id_rd_i & (cur_id_i == ID_TXE));

  // set wins over a same-cycle clear
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)     pend_o <= 1'b0;
    else if (set_ev) pend_o <= 1'b1;
    else if (clr_ev) pend_o <= 1'b0;
  end

  AST_TXE_RD_CLR: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (id_rd_i && cur_id_i == ID_TXE && !xmit_done_i && !(ier_wr_i && thr_empty_i))
    |=> !pend_o); // R7
  AST_TXE_WR_CLR: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (thr_wr_i && !xmit_done_i && !(ier_wr_i && thr_empty_i)) |=> !pend_o); // R7
  AST_TXE_SET: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (xmit_done_i || (ier_wr_i && thr_empty_i)) |=> pend_o); // R8
endmodule

// File: rtl/irq_prio_enc.sv
module irq_prio_enc
  import serial_irq_pkg::*;
#(
  parameter int CNT_W = 5
) (
  input  logic [EN_W-1:0]  en_i,
  input  logic [3:0]       line_err_i,
  input  logic             tmo_i,
  input  logic             data_ready_i,
  input  logic             fifo_en_i,
  input  logic [CNT_W-1:0] rx_count_i,
  input  logic [CNT_W-1:0] rx_level_i,
  input  logic             txe_pend_i,
  input  logic [3:0]       modem_delta_i,
  output irq_id_e          id_o
);
  logic [NUM_SRC-1:0] req;
  logic               rx_qual;

  assign rx_qual = data_ready_i & (!fifo_en_i || (rx_count_i >= rx_level_i));

  // index = rank
  assign req[0] = en_i[EN_LINE]  & (|line_err_i);
  assign req[1] = en_i[EN_RX]    & tmo_i;
  assign req[2] = en_i[EN_RX]    & rx_qual;
  assign req[3] = en_i[EN_TXE]   & txe_pend_i;
  assign req[4] = en_i[EN_MODEM] & (|modem_delta_i);

  irq_id_e rank_ids [NUM_SRC];
  for (genvar g = 0; g < NUM_SRC; g++) begin : g_ids
    assign rank_ids[g] = rank_id(g);
  end

  always_comb begin
    id_o = ID_NONE;
    for (int i = NUM_SRC - 1; i >= 0; i--) begin
      if (req[i]) id_o = rank_ids[i];
    end
  end
endmodule

// File: rtl/serial_irq_arbiter.sv
module serial_irq_arbiter
  import serial_irq_pkg::*;
#(
  parameter int CNT_W = 5
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             ier_wr_i,
  input  logic [7:0]       ier_wdata_i,
  output logic [7:0]       ier_o,
  input  logic             iir_rd_i,
  output logic [7:0]       iir_o,
  input  logic             thr_wr_i,
  input  logic             thr_empty_i,
  input  logic             xmit_done_i,
  input  logic             fifo_en_i,
  input  logic [3:0]       line_err_i,
  input  logic             char_tmo_i,
  input  logic             data_ready_i,
  input  logic [CNT_W-1:0] rx_count_i,
  input  logic [CNT_W-1:0] rx_level_i,
  input  logic [3:0]       modem_delta_i,
  output logic             irq_o
);
  logic [EN_W-1:0] en_q;
  logic            txe_pend;
  irq_id_e         cur_id;

  irq_enable_reg u_en (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .wr_i    (ier_wr_i),
    .wdata_i (ier_wdata_i),
    .en_o    (en_q)
  );

  txe_pending u_txe (
    .clk_i       (clk_i),
    .rst_ni      (rst_ni),
    .xmit_done_i (xmit_done_i),
    .ier_wr_i    (ier_wr_i),
    .thr_empty_i (thr_empty_i),
    .thr_wr_i    (thr_wr_i),
    .id_rd_i     (iir_rd_i),
    .cur_id_i    (cur_id),
    .pend_o      (txe_pend)
  );

  irq_prio_enc #(.CNT_W(CNT_W)) u_enc (
    .en_i          (en_q),
    .line_err_i    (line_err_i),
    .tmo_i         (char_tmo_i),
    .data_ready_i  (data_ready_i),
    .fifo_en_i     (fifo_en_i),
    .rx_count_i    (rx_count_i),
    .rx_level_i    (rx_level_i),
    .txe_pend_i    (txe_pend),
    .modem_delta_i (modem_delta_i),
    .id_o          (cur_id)
  );

  assign ier_o = {{(REG_W-EN_W){1'b0}}, en_q};
  assign iir_o = {{2{fifo_en_i}}, 2'b00, cur_id};
  assign irq_o = (cur_id != ID_NONE);

  AST_LINE_TOP: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (ier_o[EN_LINE] && |line_err_i) |-> iir_o[3:0] == ID_LINE); // R1
  AST_TMO_GATED: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !ier_o[EN_RX] |-> iir_o[3:0] != ID_TMO); // R5
  AST_FIFO_TAG: assert property (@(posedge clk_i) disable iff (!rst_ni)
    iir_o[7:4] == {fifo_en_i, fifo_en_i, 2'b00}); // R9
  AST_IRQ_LEVEL: assert property (@(posedge clk_i) disable iff (!rst_ni)
    irq_o == (iir_o[3:0] != ID_NONE)); // R10
endmodule

// File: tb/sim_serial_irq_arbiter.sv
module sim_serial_irq_arbiter;
  localparam int CNT_W = 5;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic ier_wr = 0, iir_rd = 0, thr_wr = 0, thr_empty = 0, xmit_done = 0;
  logic [7:0] ier_wd = '0;
  logic fifo_en = 0, tmo = 0, dr = 0;
  logic [3:0] lerr = '0, mdelta = '0;
  logic [CNT_W-1:0] cnt = '0, lvl = '0;
  logic [7:0] ier_q, iir_q;
  logic irq;

  int checks = 0, fails = 0;
  bit done = 0;

  always #5 clk = ~clk;

  serial_irq_arbiter #(.CNT_W(CNT_W)) u0 (
    .clk_i(clk), .rst_ni(rst_n),
    .ier_wr_i(ier_wr), .ier_wdata_i(ier_wd), .ier_o(ier_q),
    .iir_rd_i(iir_rd), .iir_o(iir_q),
    .thr_wr_i(thr_wr), .thr_empty_i(thr_empty), .xmit_done_i(xmit_done),
    .fifo_en_i(fifo_en), .line_err_i(lerr), .char_tmo_i(tmo),
    .data_ready_i(dr), .rx_count_i(cnt), .rx_level_i(lvl),
    .modem_delta_i(mdelta), .irq_o(irq)
  );

  typedef struct packed {
    logic [7:0]       ier;
    logic [3:0]       lerr;
    logic             tmo;
    logic             dr;
    logic [CNT_W-1:0] cnt;
    logic [CNT_W-1:0] lvl;
    logic             fifo;
    logic [3:0]       md;
    logic [7:0]       exp;
  } vec_t;

  localparam int NV = 11;
  localparam vec_t VECS [NV] = '{
    '{8'h0F, 4'h1, 1'b1, 1'b1, 5'd5,  5'd1,  1'b1, 4'hF, 8'hC6}, // R1 R4 overrun wins
    '{8'h0F, 4'h0, 1'b1, 1'b1, 5'd5,  5'd1,  1'b1, 4'hF, 8'hCC}, // R1 R2 timeout next
    '{8'h0F, 4'h0, 1'b0, 1'b1, 5'd4,  5'd4,  1'b1, 4'hF, 8'hC4}, // R6 count at level
    '{8'h0F, 4'h0, 1'b0, 1'b1, 5'd3,  5'd4,  1'b1, 4'hF, 8'hC0}, // R6 below level
    '{8'h0F, 4'h0, 1'b0, 1'b1, 5'd0,  5'd14, 1'b0, 4'h0, 8'h04}, // R6 R9 fifo off
    '{8'h0B, 4'hF, 1'b0, 1'b0, 5'd0,  5'd1,  1'b1, 4'h1, 8'hC0}, // R3 R4 line masked
    '{8'h0E, 4'h0, 1'b1, 1'b1, 5'd9,  5'd1,  1'b1, 4'h0, 8'hC1}, // R5 timeout masked
    '{8'h01, 4'h0, 1'b1, 1'b0, 5'd0,  5'd1,  1'b1, 4'h0, 8'hCC}, // R5 timeout enabled
    '{8'h04, 4'h8, 1'b0, 1'b0, 5'd0,  5'd1,  1'b1, 4'h0, 8'hC6}, // R4 break
    '{8'h08, 4'h0, 1'b0, 1'b0, 5'd0,  5'd1,  1'b0, 4'h0, 8'h01}, // R10 no delta
    '{8'hF0, 4'hF, 1'b1, 1'b1, 5'd9,  5'd1,  1'b0, 4'hF, 8'h01}  // R3 upper bits ignored
  };

  task automatic chk(input string req, input logic [7:0] got, input logic [7:0] exp);
    checks++;
    if (got !== exp) begin
      fails++;
      $display("FAIL %s: got %h expected %h", req, got, exp);
    end
  endtask

  // strobe sampled by one rising edge, checked after the next falling edge
  task automatic step();
    @(negedge clk);
    ier_wr = 0; iir_rd = 0; thr_wr = 0; xmit_done = 0;
    #1;
  endtask

  task automatic write_ier(input logic [7:0] v);
    @(negedge clk);
    ier_wr = 1; ier_wd = v;
    step();
  endtask

  initial begin
    #1_000_000;
    if (!done) begin
      checks++; fails++;
      $display("FAIL watchdog: got timeout expected completion");
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    #1;
    chk("R11 iir", iir_q, 8'h01);
    chk("R11 irq", {7'b0, irq}, 8'h00);
    chk("R11 ier", ier_q, 8'h00);
    @(negedge clk);
    rst_n = 1;

    for (int i = 0; i < NV; i++) begin
      write_ier(VECS[i].ier);
      @(negedge clk);
      lerr = VECS[i].lerr; tmo = VECS[i].tmo; dr = VECS[i].dr;
      cnt = VECS[i].cnt; lvl = VECS[i].lvl; fifo_en = VECS[i].fifo;
      mdelta = VECS[i].md;
      #1;
      chk("R1 R2 vector iir", iir_q, VECS[i].exp);
      chk("R10 vector irq", {7'b0, irq}, {7'b0, VECS[i].exp[3:0] != 4'h1});
    end

    lerr = 0; tmo = 0; dr = 0; mdelta = 0; fifo_en = 0;
    write_ier(8'hF3);
    chk("R3 readback", ier_q, 8'h03);

    // R8 R12: ier write with holding register empty arms transmit-empty
    thr_empty = 1;
    write_ier(8'h02);
    chk("R8 ier write sets", iir_q, 8'h02);
    chk("R10 irq on txe", {7'b0, irq}, 8'h01);
    @(negedge clk); iir_rd = 1;
    step();
    chk("R7 read clears", iir_q, 8'h01);

    // R7: read while higher source shown leaves flag
    thr_empty = 0;
    write_ier(8'h03);
    @(negedge clk); xmit_done = 1;
    step();
    chk("R8 xmit done sets", iir_q, 8'h02);
    dr = 1; #1;
    chk("R12 combinational rx", iir_q, 8'h04);
    @(negedge clk); iir_rd = 1;
    step();
    dr = 0; #1;
    chk("R7 other read keeps", iir_q, 8'h02);
    @(negedge clk); thr_wr = 1;
    step();
    chk("R7 thr write clears", iir_q, 8'h01);

    // R8: set beats clear in the same cycle
    @(negedge clk); thr_wr = 1; xmit_done = 1;
    step();
    chk("R8 set wins", iir_q, 8'h02);

    // R12: disabling takes effect right after the write edge
    write_ier(8'h00);
    chk("R12 disable next cycle", iir_q, 8'h01);
    fifo_en = 1; #1;
    chk("R9 fifo tag", iir_q, 8'hC1);

    done = 1;
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end
endmodule